// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Reload

This block guards a processor against runaway software. A 24-bit down-counter is loaded from a reload constant and counts down once every four clock cycles. Software must restart the count in time by writing a two-byte key to the key register. If the count reaches zero first, the block pulses its reset output and records a sticky time-out flag. A window limit refuses restarts that come too early. A warning level raises an interrupt shortly before expiry.

The watchdog starts in a disarmed state. Setting the run bit on its own does nothing. The watchdog arms on the first complete key pair written after the run bit is set. From then on, a broken key sequence, an early restart or a guarded reload change each cause a reset two clocks later. Before arming, those same faults are silently ignored.

The lock bit protects the reload constant. While the lock bit is set, the reload constant may only be rewritten once the count has fallen to the warning level or to the window limit. The run bit and the lock bit can only be cleared by the block's own reset. The bus and the counter share one clock. Each register access lasts one cycle, and reads return data combinationally.

Top module: `wdog_window`

## Requirements
- R1: After reset, the registers read as follows: control (address 0) reads 0, reload (address 1) reads 0x0000FF, count (address 3) reads 0x0000FF, warning level (address 4) reads 0 and window limit (address 5) reads 0xFFFFFF. Both outputs are low.
- R2: Any write to the reload register (address 1) stores the 24-bit value written. A value below 0xFF is stored as 0xFF instead.
- R3: While disarmed, the count holds its value. While armed, the count falls by one on every fourth clock edge after the last restart.
- R4: A restart is a write of 0xAA to key register address 2, followed directly by a write of 0x55 to the same register as the next access. A restart loads the count from the reload register. If the run bit (control bit 0) is set, the restart also arms the watchdog.
- R5: While disarmed, a broken key sequence or any other fault never asserts `wdt_rst`.
- R6: While armed, any access after a 0xAA key write, other than a 0x55 key write, is a fault. A fault sets the time-out flag (control bit 2) and pulses `wdt_rst` for one cycle. The pulse comes in the second cycle after the access.
- R7: While armed, a 0x55 key write that completes the pair while the count is above the window limit is a fault. That restart is not performed.
- R8: While armed, the clock edge that would take the count below zero pulses `wdt_rst` for one cycle in the following cycle. The same edge sets the time-out flag and reloads the count. With a reload value of N, this happens 4×(N+1) edges after the restart.
- R9: While the lock bit (control bit 1) is set, a write to the reload register is discarded if the count is above both the warning level and the window limit. If the watchdog is armed, that write is also a fault.
- R10: `wdt_irq` is high exactly while the watchdog is armed and the count is at or below the 10-bit warning level.
- R11: Writing 0 to control bit 2 clears the time-out flag. Writing 1 to that bit has no effect. If the flag is being set in the same cycle as a clear write, the set wins.
- R12: Writing 1 sets the run bit and the lock bit. Once set, neither bit can be cleared except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wdt_rst | output | 1 | One-cycle reset request |
| wdt_irq | output | 1 | Warning interrupt, level |

## Verification
A time-out flag set can land in the same cycle as a software write that clears the flag. The bench provokes this by following a faulting access with a control write that clears the flag. That control write falls exactly on the edge where the delayed fault sets the flag, and the bench then reads the flag back and expects it set. The bench also lines up a fault from an early restart, and a discarded locked reload write, against a running count. In each case it judges the exact cycle of the `wdt_rst` pulse and the reload value read back afterwards.

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int CW         = 24,
  parameter int WW         = 10,
  parameter int PRE_W      = 2,
  parameter int RELOAD_MIN = 'hFF,
  parameter int KEY_A      = 'hAA,
  parameter int KEY_B      = 'h55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst,
  output logic        wdt_irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_RELOAD = 3'd1, A_KEY = 3'd2,
                         A_COUNT = 3'd3, A_WARN = 3'd4, A_WIN = 3'd5;
  localparam logic [CW-1:0] FLOOR = CW'(RELOAD_MIN);

  logic [CW-1:0]    count_q, reload_q, window_q;
  logic [WW-1:0]    warn_q;
  logic [PRE_W-1:0] pre_q;
  logic en_q, prot_q, flag_q, armed_q, pend_q, err_q, rst_q;

  wire access   = bus_wr | bus_rd;
  wire ctrl_wr  = bus_wr && bus_addr == A_CTRL;
  wire rel_wr   = bus_wr && bus_addr == A_RELOAD;
  wire key_wr   = bus_wr && bus_addr == A_KEY;
  wire key_a    = key_wr && bus_wdata[7:0] == 8'(KEY_A);
  wire key_b    = key_wr && bus_wdata[7:0] == 8'(KEY_B);
  wire [CW-1:0] warn_ext = CW'(warn_q);
  wire early    = count_q > window_q;
  wire seq_bad  = pend_q && access && !key_b;
  wire win_bad  = pend_q && key_b && early;
  wire prot_bad = prot_q && rel_wr && count_q > warn_ext && early;
  wire feed_ok  = pend_q && key_b && !(armed_q && early);
  wire fault    = armed_q && (seq_bad || win_bad || prot_bad);
  wire tick     = armed_q && pre_q == '1;
  wire expire   = tick && count_q == '0;
  wire trip     = err_q || expire;
  wire [CW-1:0] wr_val = bus_wdata[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= FLOOR;
      reload_q <= FLOOR;
      window_q <= '1;
      warn_q   <= '0;
      pre_q    <= '0;
      en_q     <= 1'b0;
      prot_q   <= 1'b0;
      flag_q   <= 1'b0;
      armed_q  <= 1'b0;
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      if (access) pend_q <= !pend_q && key_a;
      err_q <= fault;
      rst_q <= trip;
      if (feed_ok) begin
        count_q <= reload_q;
        pre_q   <= '0;
        armed_q <= armed_q | en_q;
      end else if (armed_q) begin
        pre_q <= pre_q + 1'b1;
        if (tick) count_q <= expire ? reload_q : count_q - 1'b1;
      end
      if (trip) flag_q <= 1'b1;
      else if (ctrl_wr && !bus_wdata[2]) flag_q <= 1'b0;
      if (ctrl_wr) begin
        en_q   <= en_q | bus_wdata[0];
        prot_q <= prot_q | bus_wdata[1];
      end
      if (rel_wr && !prot_bad) reload_q <= (wr_val < FLOOR) ? FLOOR : wr_val;
      if (bus_wr && bus_addr == A_WARN) warn_q <= bus_wdata[WW-1:0];
      if (bus_wr && bus_addr == A_WIN) window_q <= wr_val;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata[2:0] = {flag_q, prot_q, en_q};
      A_RELOAD: bus_rdata[CW-1:0] = reload_q;
      A_COUNT:  bus_rdata[CW-1:0] = count_q;
      A_WARN:   bus_rdata[WW-1:0] = warn_q;
      A_WIN:    bus_rdata[CW-1:0] = window_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign wdt_rst = rst_q;
  assign wdt_irq = armed_q && count_q <= warn_ext;

  AST_RUN_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) en_q |=> en_q);       // R12
  AST_LOCK_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) prot_q |=> prot_q);   // R12
  AST_RST_ARMED:    assert property (@(posedge clk) disable iff (!rst_n) wdt_rst |-> armed_q); // R5
  AST_RST_FLAG:     assert property (@(posedge clk) disable iff (!rst_n) wdt_rst |-> flag_q);  // R6
  AST_IRQ_ARMED:    assert property (@(posedge clk) disable iff (!rst_n) wdt_irq |-> armed_q); // R10
  AST_HOLD_DISARM:  assert property (@(posedge clk) disable iff (!rst_n)
                      (!armed_q && !feed_ok) |=> $stable(count_q));                             // R3
endmodule

// File: tb/test_wdog_window.sv
`timescale 1ns/1ps
module test_wdog_window;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic wdt_rst, wdt_irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  wdog_window i_wdog_window (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst(wdt_rst), .wdt_irq(wdt_irq));

  function automatic logic [31:0] clamp(input logic [31:0] v);
    logic [31:0] m = v & 32'hFFFFFF;
    return (m < 32'hFF) ? 32'hFF : m;
  endfunction

  function automatic logic [31:0] exp_count(input logic [31:0] rel, input int edges);
    return rel - 32'(edges / 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic feed();
    wr(3'd2, 32'hAA); wr(3'd2, 32'h55);
  endtask

  task automatic chk_pulse(input string req);
    chk(req, {31'b0, wdt_rst}, 32'd0);
    @(negedge clk); chk(req, {31'b0, wdt_rst}, 32'd1);
    @(negedge clk); chk(req, {31'b0, wdt_rst}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, rel;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 reload", v, 32'hFF);
    rd(3'd3, v); chk("R1 count", v, 32'hFF);
    rd(3'd4, v); chk("R1 warn", v, 0);
    rd(3'd5, v); chk("R1 window", v, 32'hFFFFFF);
    chk("R1 outputs", {30'b0, wdt_rst, wdt_irq}, 0);
    // R2 random reload clamp
    for (int i = 0; i < 10; i++) begin
      v = (i < 3) ? 32'($urandom_range(0, 254)) : $urandom;
      wr(3'd1, v);
      rd(3'd1, rel); chk("R2 clamp", rel, clamp(v));
    end
    wr(3'd1, 32'h0); rd(3'd1, v); chk("R2 zero", v, 32'hFF);
    // R4 restart while disarmed loads, R3 count holds
    wr(3'd1, 32'h300); feed();
    rd(3'd3, v); chk("R4 disarmed load", v, 32'h300);
    repeat (10) @(negedge clk);
    rd(3'd3, v); chk("R3 hold", v, 32'h300);
    // R5 broken pair while disarmed
    wr(3'd2, 32'hAA); rd(3'd3, v);
    for (int i = 0; i < 4; i++) begin
      chk("R5 no reset", {31'b0, wdt_rst}, 0); @(negedge clk);
    end
    // arm, then random restarts and countdown
    wr(3'd0, 32'h1);
    for (int i = 0; i < 8; i++) begin
      int n;
      rel = 32'h100 + 32'($urandom_range(0, 32'h300));
      wr(3'd1, rel); feed();
      n = $urandom_range(0, 60);
      repeat (n) @(negedge clk);
      rd(3'd3, v); chk("R3 R4 countdown", v, exp_count(rel, n));
    end
    // R6 broken sequence once armed
    wr(3'd2, 32'hAA); rd(3'd3, v);
    chk_pulse("R6 pulse");
    rd(3'd0, v); chk("R6 flag", v, 32'h5);
    wr(3'd0, 32'h1); rd(3'd0, v); chk("R11 clear", v, 32'h1);
    wr(3'd0, 32'h0); rd(3'd0, v); chk("R12 run kept", v, 32'h1);
    // R7 early restart
    wr(3'd1, 32'h200); feed();
    wr(3'd5, 32'h100);
    wr(3'd2, 32'hAA); wr(3'd2, 32'h55);
    chk_pulse("R7 pulse");
    rd(3'd3, v); chk("R7 no reload", {31'b0, v < 32'h200}, 1);
    wr(3'd5, 32'hFFFFFF);
    // R9 locked reload
    wr(3'd1, 32'hFF); feed();
    wr(3'd0, 32'h3); wr(3'd4, 32'h10); wr(3'd5, 32'h80);
    wr(3'd1, 32'h400);
    chk_pulse("R9 pulse");
    rd(3'd1, v); chk("R9 discarded", v, 32'hFF);
    repeat (520) @(negedge clk);
    wr(3'd1, 32'h500); rd(3'd1, v); chk("R9 late accepted", v, 32'h500);
    wr(3'd5, 32'hFFFFFF); wr(3'd1, 32'h100);
    // R8 and R10 expiry with warning level 0x10
    feed();
    repeat (958) @(negedge clk); chk("R10 irq low", {31'b0, wdt_irq}, 0);
    repeat (3) @(negedge clk);   chk("R10 irq high", {31'b0, wdt_irq}, 1);
    repeat (66) @(negedge clk);  chk("R8 before", {31'b0, wdt_rst}, 0);
    @(negedge clk); chk("R8 pulse", {31'b0, wdt_rst}, 1);
    @(negedge clk); chk("R8 end", {31'b0, wdt_rst}, 0);
    chk("R10 irq after reload", {31'b0, wdt_irq}, 0);
    rd(3'd3, v); chk("R8 reload", v, 32'h100);
    rd(3'd0, v); chk("R8 flag", v, 32'h7);
    // R11 set and clear in the same cycle
    wr(3'd0, 32'h3); rd(3'd0, v); chk("R11 clear", v, 32'h3);
    wr(3'd2, 32'hAA); wr(3'd0, 32'h3); wr(3'd0, 32'h3);
    rd(3'd0, v); chk("R11 set wins", v, 32'h7);
    // R12 sticky bits
    wr(3'd0, 32'h0); rd(3'd0, v); chk("R12 sticky", v, 32'h3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule